// File: doc/BRIEF.md
# Pixel Colour Selector with Composite Sync

This block produces the final digital colour of every pixel of a raster display, together with one composite sync line. Outside the visible picture area it sends out a 3-bit border colour. Inside the picture area a one-bit serial pixel stream chooses between two colours carried in an 8-bit attribute: the foreground colour (ink) for a set pixel, and the background colour (paper) for a clear pixel. A brightness flag from the same attribute goes out beside the colour bits, so that an analogue driver further down the chain can raise the intensity.

The attribute is taken in on a phase strobe that marks the start of each new pixel byte. The attribute seen on the strobe cycle applies at once to that cycle's pixel. The attribute is then held until the next strobe, so the attribute input can change freely between strobes. Horizontal and vertical sync are merged by exclusive-OR into one composite sync. Every output comes from a register on the pixel clock, so the output shows a given cycle's inputs one clock after they are sampled.

Top module: `colour_sync_unit`

## Requirements
- R1: While rst_n is low, every output (red_o, green_o, blue_o, bright_o, csync_o) is 0, whatever the inputs.
- R2: When vid_en is 0, the colour outputs show border_in one clock later, with blue_o = border_in[0], red_o = border_in[1] and green_o = border_in[2].
- R3: When vid_en is 1 and pix_in is 1, the colour outputs show the ink field (attribute bits [2:0], bit 0 blue, bit 1 red, bit 2 green) of the effective attribute one clock later.
- R4: When vid_en is 1 and pix_in is 0, the colour outputs show the paper field (attribute bits [5:3], bit 3 blue, bit 4 red, bit 5 green) of the effective attribute one clock later.
- R5: The effective attribute is attr_in in a cycle where phase_stb is 1. In any other cycle it is the value attr_in had at the last strobe (0 after reset). Changes on attr_in without a strobe do not change the outputs.
- R6: bright_o follows attribute bit 6 of the effective attribute one clock later while vid_en is 1. It is forced to 0 in any cycle where vid_en is 0.
- R7: csync_o equals hsync_in XOR vsync_in, one clock later.
- R8: Attribute bit 7 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | 1 | Serial pixel bit, 1 selects ink |
| vid_en | input | 1 | High inside the active picture area |
| phase_stb | input | 1 | Attribute capture strobe, marks the start of a pixel byte |
| attr_in | input | 8 | Attribute: [2:0] ink, [5:3] paper, [6] bright, [7] unused here |
| border_in | input | 3 | Border colour, bit 0 blue, bit 1 red, bit 2 green |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| red_o | output | 1 | Red output |
| green_o | output | 1 | Green output |
| blue_o | output | 1 | Blue output |
| bright_o | output | 1 | Intensity flag |
| csync_o | output | 1 | Composite sync |

## Verification
The only internal state is the held attribute. A wrong capture shows on the ports at the first active pixel after a strobe-free cycle: ink, paper or bright comes out different from the attribute presented at the last strobe, one clock after that pixel is sampled. A held value that is stale or corrupted by a non-strobe cycle is therefore seen within one clock of the next active pixel that reads the affected field. A flaw in the border path or in the sync merge has no state behind it, and it shows on the very next clock.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int COL_W  = 3;
  localparam int ATTR_W = 2 * COL_W + 2;

  typedef logic [COL_W-1:0] colour_t;

  typedef struct packed {
    logic    flash;
    logic    bright;
    colour_t paper;
    colour_t ink;
  } attr_t;

  // Colour for one pixel: border outside the picture, else ink/paper by pixel
  function automatic colour_t pick_colour(input logic en, input logic pix,
                                          input attr_t a, input colour_t bdr);
    colour_t c;
    if (!en)      c = bdr;
    else if (pix) c = a.ink;
    else          c = a.paper;
    return c;
  endfunction

  // Intensity is only meaningful inside the picture area
  function automatic logic pick_bright(input logic en, input attr_t a);
    return en & a.bright;
  endfunction

  function automatic logic merge_sync(input logic h, input logic v);
    return h ^ v;
  endfunction
endpackage

// File: rtl/csel_attr_hold.sv
module csel_attr_hold
  import csel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stb,
  input  attr_t attr_in,
  output attr_t attr_eff,
  output attr_t attr_held
);
  attr_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (stb) held_q <= attr_in;
  end

  // The strobe cycle already uses the fresh attribute
  assign attr_eff  = stb ? attr_in : held_q;
  assign attr_held = held_q;
endmodule

// File: rtl/csel_pixel_mux.sv
module csel_pixel_mux
  import csel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    pix,
  input  attr_t   attr,
  input  colour_t border,
  output colour_t colour_q,
  output logic    bright_q
);
  colour_t colour_d;
  logic    bright_d;

  always_comb begin
    colour_d = pick_colour(en, pix, attr, border);
    bright_d = pick_bright(en, attr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colour_q <= '0;
      bright_q <= 1'b0;
    end else begin
      colour_q <= colour_d;
      bright_q <= bright_d;
    end
  end
endmodule

// File: rtl/csel_sync_comb.sv
module csel_sync_comb
  import csel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  output logic csync_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csync_q <= 1'b0;
    else        csync_q <= merge_sync(hsync, vsync);
  end
endmodule

// File: rtl/colour_sync_unit.sv
module colour_sync_unit
  import csel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_in,
  input  logic       vid_en,
  input  logic       phase_stb,
  input  logic [7:0] attr_in,
  input  logic [2:0] border_in,
  input  logic       hsync_in,
  input  logic       vsync_in,
  output logic       red_o,
  output logic       green_o,
  output logic       blue_o,
  output logic       bright_o,
  output logic       csync_o
);
  attr_t   attr_eff;
  attr_t   attr_held;
  colour_t colour_q;

  csel_attr_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (phase_stb),
    .attr_in  (attr_t'(attr_in)),
    .attr_eff (attr_eff),
    .attr_held(attr_held)
  );

  csel_pixel_mux u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (vid_en),
    .pix     (pix_in),
    .attr    (attr_eff),
    .border  (colour_t'(border_in)),
    .colour_q(colour_q),
    .bright_q(bright_o)
  );

  csel_sync_comb u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .hsync  (hsync_in),
    .vsync  (vsync_in),
    .csync_q(csync_o)
  );

  // Field order inside a colour: bit 0 blue, bit 1 red, bit 2 green
  assign blue_o  = colour_q[0];
  assign red_o   = colour_q[1];
  assign green_o = colour_q[2];
endmodule

// File: rtl/colour_sync_unit_chk.sv
module colour_sync_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_in,
  input logic       vid_en,
  input logic       phase_stb,
  input logic [7:0] attr_in,
  input logic [2:0] border_in,
  input logic       hsync_in,
  input logic       vsync_in,
  input logic       red_o,
  input logic       green_o,
  input logic       blue_o,
  input logic       bright_o,
  input logic       csync_o,
  input logic [7:0] attr_held
);
  logic [2:0] rgb;
  assign rgb = {green_o, red_o, blue_o};

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (rgb == 3'b000 && !bright_o && !csync_o));

  a_r2_border: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_en |=> rgb == $past(border_in));

  a_r3_ink_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && pix_in && phase_stb) |=> rgb == $past(attr_in[2:0]));

  a_r4_paper_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && !pix_in && phase_stb) |=> rgb == $past(attr_in[5:3]));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_stb |=> $stable(attr_held));

  a_r5_use_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && pix_in && !phase_stb) |=> rgb == $past(attr_held[2:0]));

  a_r6_bright_border: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_en |=> !bright_o);

  a_r6_bright_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_en && phase_stb) |=> bright_o == $past(attr_in[6]));

  a_r7_csync: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> csync_o == ($past(hsync_in) ^ $past(vsync_in)));
endmodule

bind colour_sync_unit colour_sync_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_in   (pix_in),
  .vid_en   (vid_en),
  .phase_stb(phase_stb),
  .attr_in  (attr_in),
  .border_in(border_in),
  .hsync_in (hsync_in),
  .vsync_in (vsync_in),
  .red_o    (red_o),
  .green_o  (green_o),
  .blue_o   (blue_o),
  .bright_o (bright_o),
  .csync_o  (csync_o),
  .attr_held(attr_held)
);

// File: tb/tb_colour_sync_unit.sv
module tb_colour_sync_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_in = 1'b0, vid_en = 1'b0, phase_stb = 1'b0;
  logic [7:0] attr_in = '0;
  logic [2:0] border_in = '0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic       red_o, green_o, blue_o, bright_o, csync_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [2:0] rgb;
    logic       br;
    logic       cs;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model_held = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  colour_sync_unit dut (.*);

  // Driver: present one cycle of inputs and push the expected outputs
  task automatic drive(input logic p, input logic en, input logic stb,
                       input logic [7:0] a, input logic [2:0] bdr,
                       input logic h, input logic v, input string tag);
    exp_t       e;
    logic [7:0] eff;
    @(negedge clk);
    pix_in = p; vid_en = en; phase_stb = stb;
    attr_in = a; border_in = bdr; hsync_in = h; vsync_in = v;
    eff = stb ? a : model_held;
    if (!en)    e.rgb = bdr;
    else if (p) e.rgb = eff[2:0];
    else        e.rgb = eff[5:3];
    e.br  = en && eff[6];
    e.cs  = (h != v);
    e.tag = tag;
    sb_q.push_back(e);
    if (stb) model_held = a;
  endtask

  // Monitor: compare just after the edge that registers each cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        logic [4:0] got, want;
        e = sb_q.pop_front();
        got  = {green_o, red_o, blue_o, bright_o, csync_o};
        want = {e.rgb, e.br, e.cs};
        n_checks++;
        if (got !== want) begin
          n_fails++;
          $display("FAIL %s: got rgb/br/cs=%b expected %b", e.tag, got, want);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in reset with busy inputs
    pix_in = 1; vid_en = 1; phase_stb = 1; attr_in = 8'hFF;
    border_in = 3'b111; hsync_in = 1; vsync_in = 0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if ({green_o, red_o, blue_o, bright_o, csync_o} !== 5'b0) begin
      n_fails++;
      $display("FAIL R1: got %b expected 00000",
               {green_o, red_o, blue_o, bright_o, csync_o});
    end
    @(negedge clk);
    phase_stb = 0; vid_en = 0; border_in = 0; hsync_in = 0;
    rst_n = 1;

    // R2: every border colour, with a bright attribute presented (R6 forced low)
    for (int i = 0; i < 8; i++)
      drive(1'b1, 1'b0, 1'b0, 8'h40, 3'(i), 1'b0, 1'b0, "R2");
    // R6: strobe a bright attribute while in the border
    drive(1'b1, 1'b0, 1'b1, 8'h7F, 3'b010, 1'b0, 1'b0, "R6");

    // R7: all sync combinations
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'b001, 1'b0, 1'b1, "R7");
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'b001, 1'b1, 1'b0, "R7");
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'b001, 1'b1, 1'b1, "R7");
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'b001, 1'b0, 0, "R7");

    // R3/R4: ink=101 paper=010 bright, pixel pattern over a byte
    drive(1'b1, 1'b1, 1'b1, 8'b0101_0101, 3'b111, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 8'h00, 3'b111, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 1'b0, 8'h00, 3'b111, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 8'h00, 3'b111, 1'b0, 1'b0, "R4");
    // R5: attribute changes without strobe are ignored
    drive(1'b1, 1'b1, 1'b0, 8'b0011_1010, 3'b000, 1'b1, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, 8'b0011_1010, 3'b000, 1'b0, 1'b1, "R5");
    // R4: new byte with paper on strobe cycle, non-bright
    drive(1'b0, 1'b1, 1'b1, 8'b0011_0110, 3'b000, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 1'b0, 8'hFF, 3'b000, 1'b0, 1'b0, "R5");
    // R8: flash bit alone toggled, outputs unchanged
    drive(1'b1, 1'b1, 1'b1, 8'b1011_0110, 3'b000, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R8");
    drive(1'b1, 1'b1, 1'b1, 8'b0011_0110, 3'b000, 1'b0, 1'b0, "R8");
    // R6: bright follows attribute in picture, drops at border
    drive(1'b1, 1'b1, 1'b1, 8'b1100_0001, 3'b100, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b0, 1'b0, 8'b1100_0001, 3'b100, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b1, 1'b0, 8'h00, 3'b100, 1'b0, 1'b0, "R6");

    // Sweep every ink/paper pair with alternating pixels
    for (int k = 0; k < 64; k++) begin
      drive(1'b1, 1'b1, 1'b1, 8'(k), 3'b011, k[0], k[1], "R3");
      drive(1'b0, 1'b1, 1'b0, 8'(~k), 3'b011, k[2], k[3], "R4");
    end

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule